// File: doc/BRIEF.md
# Four-Way Queue Write Distributor

This block takes one write port and spreads the written data over four queues of equal depth. Each queue drains through its own 10-bit read port. The write port carries one, two or four 10-bit lanes, so it is 10, 20 or 40 bits wide. A wide word becomes several queue entries, and the lowest lane goes in first. A mode bit sampled during reset picks one of two ways to distribute writes:

- **Steered mode:** a 2-bit select addresses a single queue for each write.
- **Fan-out mode:** every accepted write lands in all four queues in the same cycle. Such a write is refused as a whole if any queue is full, lacks room for the whole word, or is held in partial reset.

A write is all-or-nothing. Either every lane of the word is stored in every target queue, or nothing moves. Each queue has the following:

- a full flag and an empty flag;
- its own partial-reset input, which empties only that queue.

A composite full/empty pair follows the queue currently addressed by the select input, so a producer in steered mode can watch its target directly.

Top module: `wq_fanout_dist`

## Requirements
- R1: The mode (`cfg_bcast`, 1 = fan-out) and the width code (`cfg_width`) are captured on every clock edge while `rst_n` is low. Changes on these inputs while `rst_n` is high have no effect.
- R2: In steered mode an accepted write goes only into the queue numbered by `wr_sel`, and the other three queues are left unchanged.
- R3: In fan-out mode an accepted write places identical entries into all four queues in the same cycle.
- R4: In fan-out mode a write is refused for every queue when any queue is full, any queue has fewer free entries than the word needs, or any `q_prst` bit is high.
- R5: Width code 0 gives one lane, code 1 gives two lanes, code 2 gives four lanes, and code 3 gives one lane. Lane k is `wr_data[10k+9:10k]`, and lanes enter a queue in ascending k (lane 0 first).
- R6: In steered mode a write is accepted only if the target queue is not in partial reset and has free entries for all of its lanes. A refused write changes no queue.
- R7: `rd_data[10q+9:10q]` shows the oldest entry of queue q whenever that queue is not empty. A high `rd_en[q]` removes that entry at the clock edge. `rd_en` on an empty queue has no effect.
- R8: A high `q_prst[q]` at a clock edge empties queue q and leaves the other queues untouched. While it is high, queue q neither accepts writes nor pops.
- R9: `q_empty[q]` is high exactly when queue q holds 0 entries, and `q_full[q]` is high exactly when it holds DEPTH entries. After reset all queues are empty.
- R10: `sel_full` and `sel_empty` equal the full and empty flags of the queue numbered by `wr_sel`, in both modes.
- R11: `wr_ok` is high in a cycle exactly when `wr_en` is high and the write is accepted at the next clock edge. The room check uses the fill level before any read in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset; also captures the configuration |
| cfg_bcast | input | 1 | Mode: 0 steered, 1 fan-out (captured in reset) |
| cfg_width | input | 2 | Write width code (captured in reset) |
| wr_en | input | 1 | Write request |
| wr_sel | input | 2 | Target queue in steered mode; composite-flag select |
| wr_data | input | 40 | Write word, lane 0 in the low bits |
| wr_ok | output | 1 | Write accepted this cycle |
| q_prst | input | 4 | Per-queue partial reset |
| rd_en | input | 4 | Per-queue read enable |
| rd_data | output | 40 | Oldest entry of each queue, 10 bits per queue |
| q_full | output | 4 | Per-queue full flag |
| q_empty | output | 4 | Per-queue empty flag |
| sel_full | output | 1 | Full flag of the selected queue |
| sel_empty | output | 1 | Empty flag of the selected queue |

## Verification
The bench builds the block with DEPTH = 8. At that depth a queue fills after two four-lane words or four two-lane words. The states where a word fits only partly (5 to 7 entries used with four lanes, 7 used with two lanes) therefore come up often under mixed reads and writes. Both modes are swept against all four width codes, each after a fresh reset. The configuration inputs are scrambled on every cycle after reset. A queue model in the bench predicts every flag, every head entry and every accept decision in each cycle.

// File: rtl/wqd_pkg.sv
package wqd_pkg;

  // Write width codes; the value of each code is decoded by the lane count.
  typedef enum logic [1:0] {
    WID_X1  = 2'd0,
    WID_X2  = 2'd1,
    WID_X4  = 2'd2,
    WID_RSV = 2'd3
  } wid_e;

  // Number of 10-bit lanes a write word carries for a given code.
  function automatic int unsigned lanes_of(wid_e w);
    case (w)
      WID_X2:  return 2;
      WID_X4:  return 4;
      default: return 1;
    endcase
  endfunction

  // True when a queue holding 'used' entries out of 'depth' can take 'need' more.
  function automatic logic has_room(int unsigned used, int unsigned need,
                                    int unsigned depth);
    return (used + need) <= depth;
  endfunction

endpackage

// File: rtl/wqd_cfg_latch.sv
module wqd_cfg_latch #(
  parameter int MAX_LANES = 4,
  localparam int LNW = $clog2(MAX_LANES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_bcast,
  input  logic [1:0]     cfg_width,
  output logic           bcast_q,
  output logic [LNW-1:0] nlanes_q
);
  import wqd_pkg::*;

  // Configuration follows the inputs only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcast_q  <= cfg_bcast;
      nlanes_q <= LNW'(lanes_of(wid_e'(cfg_width)));
    end
  end

endmodule

// File: rtl/wqd_admit.sv
module wqd_admit #(
  parameter int NQ        = 4,
  parameter int DEPTH     = 8,
  parameter int MAX_LANES = 4,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int SW  = $clog2(NQ),
  localparam int LNW = $clog2(MAX_LANES + 1)
) (
  input  logic                   bcast,
  input  logic [LNW-1:0]         nlanes,
  input  logic                   wr_en,
  input  logic [SW-1:0]          wr_sel,
  input  logic [NQ-1:0]          q_prst,
  input  logic [NQ-1:0][CW-1:0]  q_used,
  output logic                   wr_ok,
  output logic [NQ-1:0]          q_push
);
  import wqd_pkg::*;

  logic [NQ-1:0] room;

  // Room per queue, taken from the level before any same-cycle pop.
  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      room[q] = has_room(32'(q_used[q]), 32'(nlanes), DEPTH);
    end
  end

  always_comb begin
    if (bcast) begin
      wr_ok  = wr_en && (&room) && !(|q_prst);
      q_push = {NQ{wr_ok}};
    end else begin
      wr_ok  = wr_en && room[wr_sel] && !q_prst[wr_sel];
      q_push = '0;
      q_push[wr_sel] = wr_ok;
    end
  end

endmodule

// File: rtl/wqd_queue.sv
// One queue that takes 1..MAX_LANES entries per push and gives one per pop.
// DEPTH must be a power of two and at least MAX_LANES.
module wqd_queue #(
  parameter int LANE_W    = 10,
  parameter int MAX_LANES = 4,
  parameter int DEPTH     = 8,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int LNW = $clog2(MAX_LANES + 1),
  localparam int DW  = LANE_W * MAX_LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prst,
  input  logic              push,
  input  logic [LNW-1:0]    nlanes,
  input  logic [DW-1:0]     din,
  input  logic              rd_en,
  output logic              pop,
  output logic [LANE_W-1:0] dout,
  output logic [CW-1:0]     used,
  output logic              full,
  output logic              empty
);

  logic [LANE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     add_n;

  assign empty = (used == '0);
  assign full  = (used == CW'(DEPTH));
  assign pop   = rd_en && !empty && !prst;
  assign add_n = push ? CW'(nlanes) : '0;
  assign dout  = mem[rp];

  // Lane k of a push lands k slots after the write pointer.
  always_ff @(posedge clk) begin
    if (push) begin
      for (int k = 0; k < MAX_LANES; k++) begin
        if (LNW'(k) < nlanes) begin
          mem[wp + AW'(k)] <= din[k*LANE_W +: LANE_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || prst) begin
      wp   <= '0;
      rp   <= '0;
      used <= '0;
    end else begin
      wp   <= wp + AW'(add_n);
      rp   <= rp + AW'(pop);
      used <= used + add_n - CW'(pop);
    end
  end

endmodule

// File: rtl/wq_fanout_dist.sv
module wq_fanout_dist #(
  parameter int NQ        = 4,
  parameter int LANE_W    = 10,
  parameter int MAX_LANES = 4,
  parameter int DEPTH     = 16,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int SW  = $clog2(NQ),
  localparam int LNW = $clog2(MAX_LANES + 1),
  localparam int DW  = LANE_W * MAX_LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_bcast,
  input  logic [1:0]           cfg_width,
  input  logic                 wr_en,
  input  logic [SW-1:0]        wr_sel,
  input  logic [DW-1:0]        wr_data,
  output logic                 wr_ok,
  input  logic [NQ-1:0]        q_prst,
  input  logic [NQ-1:0]        rd_en,
  output logic [NQ*LANE_W-1:0] rd_data,
  output logic [NQ-1:0]        q_full,
  output logic [NQ-1:0]        q_empty,
  output logic                 sel_full,
  output logic                 sel_empty
);

  // Named internal events, visible to the bound checker.
  logic                  bcast_q;
  logic [LNW-1:0]        nlanes_q;
  logic [NQ-1:0]         q_push;
  logic [NQ-1:0]         q_pop;
  logic [NQ-1:0][CW-1:0] q_used;

  wqd_cfg_latch #(.MAX_LANES(MAX_LANES)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_bcast (cfg_bcast),
    .cfg_width (cfg_width),
    .bcast_q   (bcast_q),
    .nlanes_q  (nlanes_q)
  );

  wqd_admit #(.NQ(NQ), .DEPTH(DEPTH), .MAX_LANES(MAX_LANES)) u_admit (
    .bcast  (bcast_q),
    .nlanes (nlanes_q),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .q_prst (q_prst),
    .q_used (q_used),
    .wr_ok  (wr_ok),
    .q_push (q_push)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    wqd_queue #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES), .DEPTH(DEPTH)) u_queue (
      .clk    (clk),
      .rst_n  (rst_n),
      .prst   (q_prst[q]),
      .push   (q_push[q]),
      .nlanes (nlanes_q),
      .din    (wr_data),
      .rd_en  (rd_en[q]),
      .pop    (q_pop[q]),
      .dout   (rd_data[q*LANE_W +: LANE_W]),
      .used   (q_used[q]),
      .full   (q_full[q]),
      .empty  (q_empty[q])
    );
  end

  assign sel_full  = q_full[wr_sel];
  assign sel_empty = q_empty[wr_sel];

endmodule

// File: rtl/wqd_chk.sv
module wqd_chk #(
  parameter int NQ = 4,
  localparam int SW = $clog2(NQ)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bcast_q,
  input logic          wr_ok,
  input logic [SW-1:0] wr_sel,
  input logic [NQ-1:0] q_push,
  input logic [NQ-1:0] q_pop,
  input logic [NQ-1:0] q_prst,
  input logic [NQ-1:0] q_full,
  input logic [NQ-1:0] q_empty
);

  // R1
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(bcast_q));

  // R2
  steer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bcast_q |-> $onehot0(q_push));

  // R2
  steer_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bcast_q && wr_ok) |-> q_push[wr_sel]);

  // R3
  fanout_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_q && wr_ok) |-> (q_push == {NQ{1'b1}}));

  // R4
  fanout_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_q && ((|q_full) || (|q_prst))) |-> !wr_ok);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push & q_full) == '0);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop & q_empty) == '0);

  // R8
  prst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_push | q_pop) & q_prst) == '0);

  for (genvar i = 0; i < NQ; i++) begin : g_prst
    // R8
    prst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_prst[i] |=> q_empty[i]);
  end

endmodule

bind wq_fanout_dist wqd_chk #(.NQ(NQ)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bcast_q (bcast_q),
  .wr_ok   (wr_ok),
  .wr_sel  (wr_sel),
  .q_push  (q_push),
  .q_pop   (q_pop),
  .q_prst  (q_prst),
  .q_full  (q_full),
  .q_empty (q_empty)
);

// File: tb/wq_fanout_dist_tb.sv
module wq_fanout_dist_tb;
  localparam int NQ = 4;
  localparam int LW = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_bcast = 1'b0;
  logic [1:0]    cfg_width = 2'd0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [39:0]   wr_data = '0;
  logic          wr_ok;
  logic [3:0]    q_prst = '0;
  logic [3:0]    rd_en = '0;
  logic [39:0]   rd_data;
  logic [3:0]    q_full, q_empty;
  logic          sel_full, sel_empty;

  wq_fanout_dist #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_bcast(cfg_bcast), .cfg_width(cfg_width),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_ok(wr_ok),
    .q_prst(q_prst), .rd_en(rd_en), .rd_data(rd_data), .q_full(q_full),
    .q_empty(q_empty), .sel_full(sel_full), .sel_empty(sel_empty)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit lat_bcast;
  int lat_lanes;
  logic [LW-1:0] mq [NQ][$];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // R5: code 1 -> 2 lanes, code 2 -> 4 lanes, codes 0 and 3 -> 1 lane
  function automatic int lanes_for(int code);
    return (code == 1) ? 2 : (code == 2) ? 4 : 1;
  endfunction

  task automatic do_reset(bit b, int w);
    @(negedge clk);
    rst_n = 1'b0; cfg_bcast = b; cfg_width = 2'(w);
    wr_en = 1'b0; q_prst = '0; rd_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lat_bcast = b;
    lat_lanes = lanes_for(w);
    for (int q = 0; q < NQ; q++) mq[q].delete();
    #1;
    chk(q_empty == 4'hF, "R9 reset empty", longint'(q_empty), 64'hF);
    chk(q_full == 4'h0, "R9 reset full", longint'(q_full), 0);
    chk(wr_ok == 1'b0, "R11 reset wr_ok", longint'(wr_ok), 0);
  endtask

  task automatic step(bit we, int sel, logic [39:0] d, logic [3:0] pr, logic [3:0] re);
    bit acc;
    bit room_all;
    int sz;
    @(negedge clk);
    wr_en = we; wr_sel = 2'(sel); wr_data = d; q_prst = pr; rd_en = re;
    // R1: scramble configuration after reset; latched values must rule
    cfg_bcast = 1'($urandom());
    cfg_width = 2'($urandom());
    #1;
    room_all = 1'b1;
    for (int q = 0; q < NQ; q++)
      if (DEPTH - mq[q].size() < lat_lanes) room_all = 1'b0;
    if (lat_bcast)
      acc = we && room_all && (pr == 4'h0);
    else
      acc = we && !pr[sel] && (DEPTH - mq[sel].size() >= lat_lanes);
    chk(wr_ok == acc, lat_bcast ? "R11 R4 accept (cfg R1)" : "R11 R6 accept (cfg R1)",
        longint'(wr_ok), longint'(acc));
    for (int q = 0; q < NQ; q++) begin
      sz = mq[q].size();
      chk(q_empty[q] == (sz == 0), $sformatf("R9 empty q%0d", q),
          longint'(q_empty[q]), longint'(sz == 0));
      chk(q_full[q] == (sz == DEPTH), $sformatf("R9 full q%0d", q),
          longint'(q_full[q]), longint'(sz == DEPTH));
      if (sz > 0)
        chk(rd_data[q*LW +: LW] == mq[q][0],
            $sformatf("R7 R5 %s head q%0d", lat_bcast ? "R3" : "R2", q),
            longint'(rd_data[q*LW +: LW]), longint'(mq[q][0]));
    end
    chk(sel_full == (mq[sel].size() == DEPTH), "R10 sel_full",
        longint'(sel_full), longint'(mq[sel].size() == DEPTH));
    chk(sel_empty == (mq[sel].size() == 0), "R10 sel_empty",
        longint'(sel_empty), longint'(mq[sel].size() == 0));
    @(posedge clk);
    for (int q = 0; q < NQ; q++) begin
      if (pr[q]) begin
        mq[q].delete();                      // R8
      end else begin
        if (re[q] && mq[q].size() > 0) void'(mq[q].pop_front());
        if (acc && (lat_bcast || sel == q))
          for (int k = 0; k < lat_lanes; k++) mq[q].push_back(d[k*LW +: LW]);
      end
    end
  endtask

  function automatic logic [39:0] rnd40();
    return 40'({$urandom(), $urandom()});
  endfunction

  task automatic run_config(bit b, int w);
    logic [3:0] pr;
    do_reset(b, w);
    // fill with steering round robin, no reads, well past full (R6, R4)
    for (int i = 0; i < 3*DEPTH; i++) step(1'b1, i % 4, rnd40(), 4'h0, 4'h0);
    // mixed traffic with occasional partial resets (R8) and empty reads (R7)
    for (int i = 0; i < 120; i++) begin
      pr = 4'h0;
      if ($urandom() % 12 == 0) pr[$urandom() % 4] = 1'b1;
      step(($urandom() % 4) != 0, int'($urandom() % 4), rnd40(), pr, 4'($urandom()));
    end
    // one queue held in partial reset for several cycles while writes arrive
    for (int i = 0; i < 4; i++) step(1'b1, 2, rnd40(), 4'b0100, 4'hF);
    // drain everything, then keep reading empty queues
    for (int i = 0; i < 2*DEPTH; i++) step(1'b0, i % 4, rnd40(), 4'h0, 4'hF);
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < 4; w++)
        run_config(b[0], w);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 run did not finish act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule